// File: doc/BRIEF.md
# Pixel-to-LVDS 7:1 Lane Serializer

This block turns one parallel video pixel (8-bit red, green and blue, plus horizontal sync, vertical sync and data enable) into seven serial bit slots on each of four LVDS data lanes, together with the clock-lane bit pattern that frames each group of seven. It runs on a clock seven times faster than the pixel rate. Where that fast clock is shared, a slot-step input serves as a seven-phase enable: a slot advances only in cycles where the step input is high.

Which bit goes into which slot is selected at run time from three mappings: a three-lane 18-bit format that carries the six upper bits of each colour, and two four-lane 24-bit formats that differ in which bits travel on the fourth lane. A mirror control sends the seven slots of every data lane in reverse order. The pixel, the mapping select and the mirror control are sampled together at the start of each pixel. A slot-index output tells downstream logic or a checker which slot is on the lanes.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst` is high, on each clock edge `slot_idx` becomes 0, all `lane_data` bits become 0 and `lane_clk` becomes 1.
- R2: `slot_idx` counts 0,1,...,6,0 and advances one step per clock in which `slot_step` is 1. In a cycle where `slot_step` is 0, `slot_idx`, `lane_data` and `lane_clk` keep their values.
- R3: `lane_clk` is 1 in slots 0, 1, 5 and 6 and 0 in slots 2, 3 and 4.
- R4: With `map_sel`=0 (18-bit), let r,g,b be bits 7:2 of each input component. Lane 0 carries g[0],r[5],r[4],r[3],r[2],r[1],r[0] in slots 0..6. Lane 1 carries b[1],b[0],g[5],g[4],g[3],g[2],g[1]. Lane 2 carries CTL2,CTL1,CTL0,b[5],b[4],b[3],b[2]. Lane 3 is held at 0.
- R5: With `map_sel`=1 (24-bit, MSB-first), lanes 0..2 follow R4 with r,g,b being bits 7:2. Lane 3 carries 0,B1,B0,G1,G0,R1,R0 of the 8-bit inputs in slots 0..6.
- R6: With `map_sel`=2 (24-bit, LSB-first), lanes 0..2 follow R4 with r,g,b being bits 5:0. Lane 3 carries 0,B7,B6,G7,G6,R7,R6 in slots 0..6.
- R7: `map_sel`=3 produces exactly the output of `map_sel`=0.
- R8: CTL0 is `pix_hsync`, CTL1 is `pix_vsync` and CTL2 is `pix_de`. Lane 3 slot 0 (CTL3) is always 0.
- R9: With `mirror`=1, output slot k of every data lane carries the bit that R4 to R6 assign to slot 6-k. `lane_clk` is unaffected.
- R10: The pixel inputs, `map_sel` and `mirror` are sampled only at the clock edge that enters slot 0 (the first step after reset, and each step out of slot 6). A change at any other time affects only the next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock (seven times the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| slot_step | input | 1 | Slot advance enable; tie high for a dedicated 7x clock |
| pix_red | input | 8 | Red component |
| pix_grn | input | 8 | Green component |
| pix_blu | input | 8 | Blue component |
| pix_hsync | input | 1 | Horizontal sync (CTL0) |
| pix_vsync | input | 1 | Vertical sync (CTL1) |
| pix_de | input | 1 | Data enable (CTL2) |
| map_sel | input | 2 | Lane mapping: 0/3 18-bit, 1 24-bit MSB-first, 2 24-bit LSB-first |
| mirror | input | 1 | Reverse slot order on all data lanes |
| lane_data | output | 4 | Serial data lanes 0..3, one slot per step |
| lane_clk | output | 1 | Clock-lane bit for the current slot |
| slot_idx | output | 3 | Number of the slot currently on the lanes |

## Verification
Every mapping code, including the alias code 3, is run in both slot orders with a walking one across all 27 pixel bits. A single set bit lands in exactly one lane and slot, so any misplaced, swapped or duplicated bit shows up as a wrong lane word. All-zero, all-one and pseudo-random pixels are then run to catch bits that interfere with each other. Separate passes change the inputs in the middle of a pixel to show that they take effect only at the next capture, pause the slot enable to show that all outputs hold, and apply reset in the middle of a pixel to show that the slot sequence restarts at slot 0.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int SLOTS  = 7;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LANES  = 4;
    localparam int COMP_W = 8;
    localparam int NARROW_W = 6;

    // bit k = clock-lane level in slot k
    localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_NARROW  = 2'd0,
        MAP_WIDE_HI = 2'd1,
        MAP_WIDE_LO = 2'd2,
        MAP_ALIAS   = 2'd3
    } map_e;

    typedef logic [SLOTS-1:0]            slot_vec_t;
    typedef logic [LANES-1:0][SLOTS-1:0] lane_pat_t;

endpackage

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_ser_pkg::*;
(
    input  logic [COMP_W-1:0] red,
    input  logic [COMP_W-1:0] grn,
    input  logic [COMP_W-1:0] blu,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              de,
    input  logic [1:0]        map_sel,
    output lane_pat_t         pat
);

    localparam int SHIFT = COMP_W - NARROW_W;

    logic                low_sel;
    logic [NARROW_W-1:0] r6, g6, b6;

    assign low_sel = (map_sel == MAP_WIDE_LO);

    // Six-bit view of each component: upper bits normally, lower bits for the LSB-first format
    for (genvar i = 0; i < NARROW_W; i++) begin : g_narrow
        assign r6[i] = low_sel ? red[i] : red[i+SHIFT];
        assign g6[i] = low_sel ? grn[i] : grn[i+SHIFT];
        assign b6[i] = low_sel ? blu[i] : blu[i+SHIFT];
    end

    always_comb begin
        // bit k of each lane word = slot k
        pat[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
        pat[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
        pat[2] = {b6[2], b6[3], b6[4], b6[5], hsync, vsync, de};
        unique case (map_sel)
            MAP_WIDE_HI: pat[3] = {red[0], red[1], grn[0], grn[1], blu[0], blu[1], 1'b0};
            MAP_WIDE_LO: pat[3] = {red[6], red[7], grn[6], grn[7], blu[6], blu[7], 1'b0};
            default:     pat[3] = '0;
        endcase
    end

endmodule

// File: rtl/lvds_slot_seq.sv
module lvds_slot_seq
    import lvds_ser_pkg::*;
(
    input  logic              started,
    input  logic [SLOT_W-1:0] slot_cur,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              capture,
    output logic              clk_bit
);

    always_comb begin
        capture  = !started || (slot_cur == SLOT_W'(SLOTS-1));
        slot_nxt = capture ? '0 : slot_cur + 1'b1;
        clk_bit  = CLK_SHAPE[slot_nxt];
    end

endmodule

// File: rtl/lvds_slot_pick.sv
module lvds_slot_pick
    import lvds_ser_pkg::*;
(
    input  lane_pat_t         pat,
    input  logic [SLOT_W-1:0] pos,
    output logic [LANES-1:0]  bits
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bits[l] = pat[l][pos];
    end

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_step,
    input  logic [COMP_W-1:0] pix_red,
    input  logic [COMP_W-1:0] pix_grn,
    input  logic [COMP_W-1:0] pix_blu,
    input  logic              pix_hsync,
    input  logic              pix_vsync,
    input  logic              pix_de,
    input  logic [1:0]        map_sel,
    input  logic              mirror,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk,
    output logic [SLOT_W-1:0] slot_idx
);

    typedef struct packed {
        logic              started;
        logic [SLOT_W-1:0] slot;
        lane_pat_t         pat;
        logic              mir;
        logic [LANES-1:0]  lane;
        logic              lclk;
    } state_t;

    localparam state_t RST_ST = '{
        started: 1'b0,
        slot:    '0,
        pat:     '0,
        mir:     1'b0,
        lane:    '0,
        lclk:    CLK_SHAPE[0]
    };

    state_t            st_d, st_q;
    lane_pat_t         map_pat, pat_src;
    logic [SLOT_W-1:0] slot_nxt, pos;
    logic              capture, clk_bit, mir_src;
    logic [LANES-1:0]  pick_bits;

    lvds_lane_mapper u_map (
        .red     (pix_red),
        .grn     (pix_grn),
        .blu     (pix_blu),
        .hsync   (pix_hsync),
        .vsync   (pix_vsync),
        .de      (pix_de),
        .map_sel (map_sel),
        .pat     (map_pat)
    );

    lvds_slot_seq u_seq (
        .started  (st_q.started),
        .slot_cur (st_q.slot),
        .slot_nxt (slot_nxt),
        .capture  (capture),
        .clk_bit  (clk_bit)
    );

    // A new pixel is read straight from the mapper; later slots come from the stored copy
    assign pat_src = capture ? map_pat : st_q.pat;
    assign mir_src = capture ? mirror  : st_q.mir;
    assign pos     = mir_src ? (SLOT_W'(SLOTS-1) - slot_nxt) : slot_nxt;

    lvds_slot_pick u_pick (
        .pat  (pat_src),
        .pos  (pos),
        .bits (pick_bits)
    );

    always_comb begin
        st_d = st_q;
        if (slot_step) begin
            st_d.started = 1'b1;
            st_d.slot    = slot_nxt;
            st_d.lane    = pick_bits;
            st_d.lclk    = clk_bit;
            if (capture) begin
                st_d.pat = map_pat;
                st_d.mir = mirror;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_ST;
        else     st_q <= st_d;
    end

    assign lane_data = st_q.lane;
    assign lane_clk  = st_q.lclk;
    assign slot_idx  = st_q.slot;

endmodule

// File: rtl/lvds_ser_chk.sv
module lvds_ser_chk
    import lvds_ser_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              slot_step,
    input logic [LANES-1:0]  lane_data,
    input logic              lane_clk,
    input logic [SLOT_W-1:0] slot_idx
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (slot_idx == '0 && lane_data == '0 && lane_clk));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= SLOT_W'(SLOTS-1));

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_step && slot_idx == SLOT_W'(SLOTS-1)) |=> slot_idx == '0);

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_step |=> ($stable(slot_idx) && $stable(lane_data) && $stable(lane_clk)));

    // R3
    clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_idx >= 3'd2 && slot_idx <= 3'd4) |-> !lane_clk);

    // R3
    clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_idx <= 3'd1 || slot_idx >= 3'd5) |-> lane_clk);

endmodule

bind lvds_pixel_serializer lvds_ser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_step (slot_step),
    .lane_data (lane_data),
    .lane_clk  (lane_clk),
    .slot_idx  (slot_idx)
);

// File: tb/lvds_pixel_serializer_tb.sv
module lvds_pixel_serializer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_step = 1'b1;
    logic [7:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
    logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
    logic [1:0] map_sel = '0;
    logic       mirror = 1'b0;
    logic [3:0] lane_data;
    logic       lane_clk;
    logic [2:0] slot_idx;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    lvds_pixel_serializer u_dut (
        .clk(clk), .rst(rst), .slot_step(slot_step),
        .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
        .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
        .map_sel(map_sel), .mirror(mirror),
        .lane_data(lane_data), .lane_clk(lane_clk), .slot_idx(slot_idx)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected slot bit from the requirement tables (R4..R8)
    function automatic bit exp_bit(input logic [26:0] v, input int m_in,
                                   input int lane, input int s);
        logic [7:0] r, g, b;
        logic [5:0] rr, gg, bb;
        int m;
        r = v[7:0]; g = v[15:8]; b = v[23:16];
        m = (m_in == 3) ? 0 : m_in;
        rr = (m == 2) ? r[5:0] : r[7:2];
        gg = (m == 2) ? g[5:0] : g[7:2];
        bb = (m == 2) ? b[5:0] : b[7:2];
        case (lane)
            0: return (s == 0) ? gg[0] : rr[6-s];
            1: return (s == 0) ? bb[1] : (s == 1) ? bb[0] : gg[7-s];
            2: return (s == 0) ? v[26] : (s == 1) ? v[25] : (s == 2) ? v[24] : bb[8-s];
            default: begin
                if (m == 0 || s == 0) return 1'b0;
                if (m == 1) begin
                    case (s)
                        1: return b[1]; 2: return b[0]; 3: return g[1];
                        4: return g[0]; 5: return r[1]; default: return r[0];
                    endcase
                end
                case (s)
                    1: return b[7]; 2: return b[6]; 3: return g[7];
                    4: return g[6]; 5: return r[7]; default: return r[6];
                endcase
            end
        endcase
    endfunction

    task automatic drive(input logic [26:0] v, input logic [1:0] m, input logic mir);
        pix_red = v[7:0]; pix_grn = v[15:8]; pix_blu = v[23:16];
        pix_hsync = v[24]; pix_vsync = v[25]; pix_de = v[26];
        map_sel = m; mirror = mir;
    endtask

    // Called just before a capture edge; returns just after the slot-6 edge
    task automatic send_pixel(input logic [26:0] v, input logic [1:0] m, input logic mir,
                              input bit chg, input bit hold, input string tag);
        logic [3:0][6:0] got;
        logic [3:0]      snap_d;
        logic [2:0]      snap_s;
        logic            snap_c;
        drive(v, m, mir);
        for (int k = 0; k < 7; k++) begin
            @(posedge clk); #2;
            // R10: disturb the inputs right after capture
            if (k == 0 && chg) drive(~v, m + 2'd1, ~mir);
            for (int l = 0; l < 4; l++) got[l][k] = lane_data[l];
            chk(slot_idx == 3'(k), "R2", "slot index", slot_idx, k);
            chk(lane_clk == ((k <= 1 || k >= 5) ? 1'b1 : 1'b0), "R3", "clock lane",
                lane_clk, (k <= 1 || k >= 5));
            if (k == 3 && hold) begin
                slot_step = 1'b0;
                snap_d = lane_data; snap_s = slot_idx; snap_c = lane_clk;
                for (int h = 0; h < 3; h++) begin
                    @(posedge clk); #2;
                    chk(lane_data == snap_d && slot_idx == snap_s && lane_clk == snap_c,
                        "R2", "hold with step low", {lane_data, slot_idx, lane_clk},
                        {snap_d, snap_s, snap_c});
                end
                slot_step = 1'b1;
            end
        end
        for (int l = 0; l < 4; l++) begin
            logic [6:0] e;
            for (int k = 0; k < 7; k++) e[k] = exp_bit(v, m, l, mir ? 6 - k : k);
            chk(got[l] == e, tag, $sformatf("lane %0d word map=%0d mir=%0d", l, m, mir),
                got[l], e);
        end
    endtask

    initial begin
        #(200000 * 8);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [26:0] lfsr;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(slot_idx == 0 && lane_data == 0 && lane_clk == 1'b1, "R1", "reset outputs",
            {slot_idx, lane_data, lane_clk}, 1);
        rst = 1'b0;

        lfsr = 27'h5a3c9e1;
        for (int m = 0; m < 4; m++) begin
            for (int mir = 0; mir < 2; mir++) begin
                string tag;
                tag = (mir != 0) ? "R9" : (m == 0) ? "R4" : (m == 1) ? "R5" :
                      (m == 2) ? "R6" : "R7";
                for (int i = 0; i < 27; i++)
                    send_pixel(27'd1 << i, 2'(m), 1'(mir), 1'b0, 1'b0,
                               (i >= 24 && mir == 0) ? "R8" : tag);
                send_pixel('0, 2'(m), 1'(mir), 1'b0, 1'b0, tag);
                send_pixel('1, 2'(m), 1'(mir), 1'b0, 1'b0, tag);
                for (int j = 0; j < 4; j++) begin
                    lfsr = {lfsr[25:0], lfsr[26] ^ lfsr[25] ^ lfsr[0]};
                    send_pixel(lfsr, 2'(m), 1'(mir), 1'b0, 1'b0, tag);
                end
            end
        end

        // R10: mid-pixel changes apply to the next pixel only
        send_pixel(27'h2a5c3f1, 2'd1, 1'b0, 1'b1, 1'b0, "R10");
        send_pixel(27'h15a3c0e, 2'd2, 1'b1, 1'b1, 1'b0, "R10");
        send_pixel(27'h7f00ff0, 2'd0, 1'b0, 1'b0, 1'b0, "R10");

        // R2: slot enable low holds everything
        send_pixel(27'h3c3c3c3, 2'd2, 1'b0, 1'b0, 1'b1, "R2");
        send_pixel(27'h4b1e2d7, 2'd1, 1'b1, 1'b0, 1'b1, "R2");

        // R1: reset in the middle of a pixel, then restart at slot 0
        @(posedge clk); @(posedge clk); #2;
        rst = 1'b1;
        @(posedge clk); #2;
        chk(slot_idx == 0 && lane_data == 0 && lane_clk == 1'b1, "R1", "mid-pixel reset",
            {slot_idx, lane_data, lane_clk}, 1);
        rst = 1'b0;
        send_pixel(27'h6d2b9a5, 2'd1, 1'b0, 1'b0, 1'b0, "R1");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule